// File: doc/BRIEF.md
# Nibble-Port Cell Receive Buffer

This block takes fixed-length cells from a 4-bit input port and hands each completed cell to logic on the system clock. The port has its own data clock, which has no fixed relation to the system clock. A start-of-cell strobe comes with the first nibble of every cell. Nibbles are paired into bytes and written into one of two cell buffers. The buffers alternate: while the system side reads one finished cell at random byte addresses, the port keeps filling the other.

When the system side has finished with a cell, it pulses a release input and the buffer goes back to the port. Handover in both directions uses toggle signals passed through two-flop synchronizers. Malformed traffic raises one of three sticky flags in the system domain: a cell cut short by an early strobe, a cell that runs on past its length, and a cell lost because both buffers were still held. The cell length is a single setting from 52 to 56 bytes.

Top module: `cell_rx_buffer`

## Requirements
- R1: A byte is formed from two accepted nibbles, the first one in bits 7:4 and the second in bits 3:0. The n-th byte of a cell (counting from 0) is read at `rd_addr` = n while `cell_full` is high. `rd_data` holds steady while the address holds and the cell is not released.
- R2: The effective cell length is `cfg_len` clamped to the range 52..56. A cell is complete when that many bytes have been accepted after its start strobe.
- R3: Up to two completed cells are held. They are presented in arrival order. `cell_full` stays high until `rd_release` is pulsed while it is high, and it stays high after that release if a second cell is waiting.
- R4: A cell that starts while the buffer it would fill is still held is discarded. At its completion `ovf_err` is set, and the held cells are unchanged.
- R5: A start strobe that arrives while a cell is still incomplete discards the partial cell, sets `short_err`, and begins a new cell.
- R6: Nibbles that arrive without a strobe after a cell has completed are ignored, and the first one sets `long_err`. The stored cell keeps its first configured-length bytes.
- R7: `short_err`, `long_err` and `ovf_err` stay set until `clr_err` is high on a system clock edge. An error that arrives on that same edge stays set.
- R8: `rd_release` has no effect while `cell_full` is low. The next arriving cell is still presented with correct data.
- R9: Port clock edges with `p_en` low carry no nibble and do not change reception.
- R10: After reset, `cell_full` and all three error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| p_clk | input | 1 | Port data clock |
| p_rst_n | input | 1 | Active-low reset, port domain |
| p_en | input | 1 | Nibble valid on this port clock edge |
| p_soc | input | 1 | Start-of-cell strobe, marks the first nibble |
| p_nib | input | 4 | Port data nibble |
| s_clk | input | 1 | System clock |
| s_rst_n | input | 1 | Active-low reset, system domain |
| cfg_len | input | 6 | Cell length in bytes (clamped 52..56), quasi-static |
| rd_addr | input | 6 | Byte index in the presented cell |
| rd_data | output | 8 | Byte of the presented cell at `rd_addr` |
| rd_release | input | 1 | Return the presented cell's buffer to the port |
| cell_full | output | 1 | A completed cell is presented |
| clr_err | input | 1 | Clear all error flags |
| short_err | output | 1 | Sticky: a cell was cut short |
| long_err | output | 1 | Sticky: a cell overran its length |
| ovf_err | output | 1 | Sticky: a cell was dropped, both buffers held |

## Verification
Each internal fault shows up at the ports in a specific way:
- A wrong fill or read buffer pointer shows up as the wrong cell's bytes, or as cells out of order. This is visible within the synchronizer delay of a few system cycles after a cell completes.
- A byte counter that is off by one moves every byte of the cell. It can also raise a spurious long-cell flag at the next gap in traffic.
- Lost toggles in the handshake leave `cell_full` stuck low, or leave a buffer that is never handed back. The latter turns the next-but-one cell into an overflow.

The sweeps cover every legal length and the clamped values on both sides. They run back-to-back and gapped traffic, and each error case ends with a read-back of the stored cells.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_RECV,
        WR_TAIL,
        WR_SKIP
    } wr_mode_e;

    localparam int EV_SHORT = 0;
    localparam int EV_LONG  = 1;
    localparam int EV_OVF   = 2;
    localparam int EV_NUM   = 3;

endpackage

// File: rtl/cellrx_sync.sv
module cellrx_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/cellrx_store.sv
module cellrx_store #(
    parameter int MAX_LEN = 56
) (
    input  logic                          wclk,
    input  logic                          we,
    input  logic                          wbuf,
    input  logic [$clog2(MAX_LEN+1)-1:0]  widx,
    input  logic [7:0]                    wdata,
    input  logic                          rbuf,
    input  logic [$clog2(MAX_LEN+1)-1:0]  ridx,
    output logic [7:0]                    rdata
);
    localparam int DEPTH = 2 * MAX_LEN;
    localparam int AW    = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;

    always_comb begin
        waddr = (wbuf ? AW'(MAX_LEN) : '0) + AW'(widx);
        raddr = (rbuf ? AW'(MAX_LEN) : '0) + AW'(ridx);
    end

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        if (int'(ridx) < MAX_LEN) rdata = mem[raddr];
        else                      rdata = '0;
    end
endmodule

// File: rtl/cellrx_wr.sv
module cellrx_wr
    import cellrx_pkg::*;
#(
    parameter int MAX_LEN = 56,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              soc,
    input  logic [3:0]        nib,
    input  logic [CNT_W-1:0]  len,
    input  logic [1:0]        rel_sync,
    output logic              we,
    output logic              wbuf,
    output logic [CNT_W-1:0]  widx,
    output logic [7:0]        wdata,
    output logic [1:0]        full_tgl,
    output logic [EV_NUM-1:0] ev_tgl
);
    typedef struct packed {
        wr_mode_e          mode;
        logic [3:0]        hi;
        logic              half;
        logic [CNT_W-1:0]  cnt;
        logic              tgt;
        logic              drop;
        logic [1:0]        full;
        logic [EV_NUM-1:0] ev;
    } wr_state_t;

    wr_state_t q, d;
    logic [1:0] busy;

    always_comb begin
        d     = q;
        busy  = q.full ^ rel_sync;
        we    = 1'b0;
        wdata = {q.hi, nib};
        if (en) begin
            if (soc) begin
                if (q.mode == WR_RECV) d.ev[EV_SHORT] = ~q.ev[EV_SHORT];
                d.mode = WR_RECV;
                d.hi   = nib;
                d.half = 1'b1;
                d.cnt  = '0;
                d.drop = busy[q.tgt];
            end else begin
                unique case (q.mode)
                    WR_RECV: begin
                        if (!q.half) begin
                            d.hi   = nib;
                            d.half = 1'b1;
                        end else begin
                            d.half = 1'b0;
                            we     = !q.drop;
                            if (q.cnt == len - CNT_W'(1)) begin
                                d.mode = WR_TAIL;
                                if (q.drop) begin
                                    d.ev[EV_OVF] = ~q.ev[EV_OVF];
                                end else begin
                                    d.full[q.tgt] = ~q.full[q.tgt];
                                    d.tgt         = ~q.tgt;
                                end
                            end else begin
                                d.cnt = q.cnt + CNT_W'(1);
                            end
                        end
                    end
                    WR_TAIL: begin
                        d.ev[EV_LONG] = ~q.ev[EV_LONG];
                        d.mode        = WR_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{mode: WR_IDLE, hi: '0, half: 1'b0, cnt: '0, tgt: 1'b0,
                   drop: 1'b0, full: '0, ev: '0};
        end else begin
            q <= d;
        end
    end

    assign wbuf     = q.tgt;
    assign widx     = q.cnt;
    assign full_tgl = q.full;
    assign ev_tgl   = q.ev;
endmodule

// File: rtl/cellrx_rd.sv
module cellrx_rd
    import cellrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        full_sync,
    input  logic [EV_NUM-1:0] ev_sync,
    input  logic              release_i,
    input  logic              clr,
    output logic              full,
    output logic              rbuf,
    output logic [1:0]        rel_tgl,
    output logic [EV_NUM-1:0] flags
);
    typedef struct packed {
        logic              rbuf;
        logic [1:0]        rel;
        logic [EV_NUM-1:0] ev_prev;
        logic [EV_NUM-1:0] flag;
    } rd_state_t;

    rd_state_t q, d;

    always_comb begin
        d    = q;
        full = full_sync[q.rbuf] ^ q.rel[q.rbuf];
        if (release_i && full) begin
            d.rel[q.rbuf] = ~q.rel[q.rbuf];
            d.rbuf        = ~q.rbuf;
        end
        d.ev_prev = ev_sync;
        d.flag    = (clr ? '0 : q.flag) | (ev_sync ^ q.ev_prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rbuf    = q.rbuf;
    assign rel_tgl = q.rel;
    assign flags   = q.flag;
endmodule

// File: rtl/cell_rx_buffer.sv
module cell_rx_buffer
    import cellrx_pkg::*;
#(
    parameter int MIN_LEN = 52,
    parameter int MAX_LEN = 56,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             p_clk,
    input  logic             p_rst_n,
    input  logic             p_en,
    input  logic             p_soc,
    input  logic [3:0]       p_nib,
    input  logic             s_clk,
    input  logic             s_rst_n,
    input  logic [CNT_W-1:0] cfg_len,
    input  logic [CNT_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    input  logic             rd_release,
    output logic             cell_full,
    input  logic             clr_err,
    output logic             short_err,
    output logic             long_err,
    output logic             ovf_err
);
    logic [CNT_W-1:0]  len_eff;
    logic              we, wbuf, rbuf;
    logic [CNT_W-1:0]  widx;
    logic [7:0]        wdata;
    logic [1:0]        full_tgl, full_s, rel_tgl, rel_p;
    logic [EV_NUM-1:0] ev_tgl, ev_s, flags;

    always_comb begin
        if (cfg_len < CNT_W'(MIN_LEN))      len_eff = CNT_W'(MIN_LEN);
        else if (cfg_len > CNT_W'(MAX_LEN)) len_eff = CNT_W'(MAX_LEN);
        else                                len_eff = cfg_len;
    end

    cellrx_wr #(.MAX_LEN(MAX_LEN)) u_wr (
        .clk(p_clk), .rst_n(p_rst_n), .en(p_en), .soc(p_soc), .nib(p_nib),
        .len(len_eff), .rel_sync(rel_p), .we(we), .wbuf(wbuf), .widx(widx),
        .wdata(wdata), .full_tgl(full_tgl), .ev_tgl(ev_tgl)
    );

    cellrx_store #(.MAX_LEN(MAX_LEN)) u_store (
        .wclk(p_clk), .we(we), .wbuf(wbuf), .widx(widx), .wdata(wdata),
        .rbuf(rbuf), .ridx(rd_addr), .rdata(rd_data)
    );

    cellrx_sync #(.W(2)) u_full_sync (
        .clk(s_clk), .rst_n(s_rst_n), .d(full_tgl), .q(full_s)
    );

    cellrx_sync #(.W(EV_NUM)) u_ev_sync (
        .clk(s_clk), .rst_n(s_rst_n), .d(ev_tgl), .q(ev_s)
    );

    cellrx_sync #(.W(2)) u_rel_sync (
        .clk(p_clk), .rst_n(p_rst_n), .d(rel_tgl), .q(rel_p)
    );

    cellrx_rd u_rd (
        .clk(s_clk), .rst_n(s_rst_n), .full_sync(full_s), .ev_sync(ev_s),
        .release_i(rd_release), .clr(clr_err), .full(cell_full),
        .rbuf(rbuf), .rel_tgl(rel_tgl), .flags(flags)
    );

    assign short_err = flags[EV_SHORT];
    assign long_err  = flags[EV_LONG];
    assign ovf_err   = flags[EV_OVF];
endmodule

// File: rtl/cell_rx_buffer_chk.sv
module cell_rx_buffer_chk #(
    parameter int AW = 6
) (
    input logic          s_clk,
    input logic          s_rst_n,
    input logic [AW-1:0] rd_addr,
    input logic [7:0]    rd_data,
    input logic          rd_release,
    input logic          cell_full,
    input logic          clr_err,
    input logic          short_err,
    input logic          long_err,
    input logic          ovf_err
);
    // R3: a presented cell stays until released
    p_full_hold_r3: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        cell_full && !rd_release |=> cell_full);

    // R1: presented bytes do not change under the reader
    p_data_stable_r1: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        cell_full && !rd_release |=> (!$stable(rd_addr) || $stable(rd_data)));

    // R7: stickiness of each flag
    p_short_sticky_r7: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        short_err && !clr_err |=> short_err);
    p_long_sticky_r7: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        long_err && !clr_err |=> long_err);
    p_ovf_sticky_r7: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        ovf_err && !clr_err |=> ovf_err);
endmodule

bind cell_rx_buffer cell_rx_buffer_chk #(.AW(CNT_W)) u_chk (
    .s_clk(s_clk), .s_rst_n(s_rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_release(rd_release), .cell_full(cell_full), .clr_err(clr_err),
    .short_err(short_err), .long_err(long_err), .ovf_err(ovf_err)
);

// File: tb/tb_cell_rx_buffer.sv
module tb_cell_rx_buffer;
    logic       p_clk = 0, s_clk = 0;
    logic       p_rst_n = 0, s_rst_n = 0;
    logic       p_en = 0, p_soc = 0;
    logic [3:0] p_nib = 0;
    logic [5:0] cfg_len = 6'd52;
    logic [5:0] rd_addr = 0;
    logic [7:0] rd_data;
    logic       rd_release = 0, cell_full, clr_err = 0;
    logic       short_err, long_err, ovf_err;

    int checks = 0, errors = 0;
    bit done = 0;

    always #13 p_clk = ~p_clk;
    always #10 s_clk = ~s_clk;

    cell_rx_buffer dut (
        .p_clk(p_clk), .p_rst_n(p_rst_n), .p_en(p_en), .p_soc(p_soc), .p_nib(p_nib),
        .s_clk(s_clk), .s_rst_n(s_rst_n), .cfg_len(cfg_len), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_release(rd_release), .cell_full(cell_full),
        .clr_err(clr_err), .short_err(short_err), .long_err(long_err), .ovf_err(ovf_err)
    );

    function automatic logic [7:0] exp_byte(int seed, int i);
        return 8'(seed * 37 + i * 11 + 5);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic nibble(logic [3:0] n, logic soc, bit gap);
        @(negedge p_clk);
        p_en = 1; p_soc = soc; p_nib = n;
        if (gap) begin
            @(negedge p_clk);
            p_en = 0; p_soc = 0; p_nib = ~n;
        end
    endtask

    // nbytes bytes, strobe on the first nibble
    task automatic send(int seed, int nbytes, bit gap);
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] b = exp_byte(seed, i);
            nibble(b[7:4], i == 0, gap);
            nibble(b[3:0], 1'b0, gap);
        end
        @(negedge p_clk);
        p_en = 0; p_soc = 0;
    endtask

    task automatic settle();
        repeat (12) @(negedge s_clk);
    endtask

    task automatic pulse_release();
        @(negedge s_clk); rd_release = 1;
        @(negedge s_clk); rd_release = 0;
    endtask

    task automatic pulse_clear();
        @(negedge s_clk); clr_err = 1;
        @(negedge s_clk); clr_err = 0;
    endtask

    task automatic read_cell(int seed, int len, string req);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        for (int w = 0; w < 400 && !cell_full; w++) @(negedge s_clk);
        chk(cell_full === 1'b1, {req, " cell_full"}, cell_full, 1);
        for (int i = 0; i < len; i++) begin
            @(negedge s_clk);
            rd_addr = 6'(i);
            #1;
            if (rd_data !== exp_byte(seed, i)) begin
                if (bad == 0) begin first_act = rd_data; first_exp = exp_byte(seed, i); end
                bad++;
            end
        end
        chk(bad == 0, {req, " cell bytes"}, first_act, first_exp);
        pulse_release();
    endtask

    initial begin
        repeat (1000000) @(posedge s_clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge s_clk);
        // R10: reset state
        chk(cell_full == 0 && short_err == 0 && long_err == 0 && ovf_err == 0,
            "R10 reset outputs", {cell_full, short_err, long_err, ovf_err}, 0);
        p_rst_n = 1; s_rst_n = 1;
        settle();
        chk(cell_full == 0, "R10 idle after reset", cell_full, 0);

        // R1 R2: sweep every legal length, back-to-back nibbles
        for (int l = 52; l <= 56; l++) begin
            cfg_len = 6'(l);
            settle();
            send(l, l, 1'b0);
            read_cell(l, l, "R1 R2 length sweep");
            chk(!short_err && !long_err && !ovf_err, "R2 no error on exact length",
                {short_err, long_err, ovf_err}, 0);
        end

        // R2: clamping above and below
        cfg_len = 6'd60; settle();
        send(90, 56, 1'b0);
        read_cell(90, 56, "R2 clamp high");
        chk(!long_err, "R2 clamp high no long", long_err, 0);
        cfg_len = 6'd40; settle();
        send(91, 52, 1'b0);
        read_cell(91, 52, "R2 clamp low");
        chk(!long_err && !short_err, "R2 clamp low no error", {short_err, long_err}, 0);

        // R9: gapped traffic
        cfg_len = 6'd53; settle();
        send(7, 53, 1'b1);
        read_cell(7, 53, "R9 gaps ignored");

        // R3: two cells held, in order
        send(11, 53, 1'b0);
        send(12, 53, 1'b0);
        settle();
        chk(cell_full == 1, "R3 first held", cell_full, 1);
        read_cell(11, 53, "R3 first cell");
        settle();
        chk(cell_full == 1, "R3 second still held", cell_full, 1);
        read_cell(12, 53, "R3 second cell");
        settle();
        chk(cell_full == 0, "R3 empty after both", cell_full, 0);

        // R4: third cell dropped
        send(21, 53, 1'b0);
        send(22, 53, 1'b0);
        send(23, 53, 1'b0);
        settle();
        chk(ovf_err == 1, "R4 overflow flagged", ovf_err, 1);
        read_cell(21, 53, "R4 held cell one");
        read_cell(22, 53, "R4 held cell two");
        settle();
        chk(cell_full == 0, "R4 dropped cell not stored", cell_full, 0);
        // R7: sticky then cleared
        chk(ovf_err == 1, "R7 ovf sticky", ovf_err, 1);
        pulse_clear(); settle();
        chk(ovf_err == 0, "R7 ovf cleared", ovf_err, 0);

        // R8: release while empty ignored
        pulse_release();
        send(31, 53, 1'b0);
        read_cell(31, 53, "R8 release on empty");

        // R5: short cell
        send(40, 10, 1'b0);
        send(41, 53, 1'b0);
        settle();
        chk(short_err == 1, "R5 short flagged", short_err, 1);
        read_cell(41, 53, "R5 following cell");
        settle();
        chk(cell_full == 0, "R5 partial cell discarded", cell_full, 0);
        pulse_clear(); settle();
        chk(short_err == 0, "R7 short cleared", short_err, 0);

        // R6: long cell
        send(50, 56, 1'b0);
        settle();
        chk(long_err == 1, "R6 long flagged", long_err, 1);
        chk(short_err == 0, "R6 no short", short_err, 0);
        read_cell(50, 53, "R6 first bytes kept");
        settle();
        chk(cell_full == 0, "R6 extra bytes not stored", cell_full, 0);
        pulse_clear(); settle();
        chk(long_err == 0, "R7 long cleared", long_err, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule